// File: doc/BRIEF.md
# Dual Leaky-Bucket Cell Policer

This block decides, for every ingress cell, whether it keeps to the traffic contract of its connection. Two leaky buckets run per connection. Each one follows the virtual-scheduling form of the generic cell rate algorithm, with its own increment, limit and theoretical arrival time (TAT). Bucket A sees every cell. Bucket B sees only cells that still carry CLP=0. Each bucket has its own action for a failing cell, programmed per connection: tag the cell (set CLP to 1) or drop it.

A cell event carries a connection index, a virtual-path index, its CLP bit and the current time. Two cycles later the block gives a verdict (pass, tag or drop), the resulting CLP bit, an overall non-conformance flag and one non-conformance flag per bucket. Downstream logic can use the overall flag to mark the cell, and statistics can count the two buckets separately. Policing applies only when the global enable is set and the enable bit for the cell's virtual path is also set. A host write port loads the parameters of one connection at a time.

Top module: `cell_policer`

## Requirements
- R1: After reset every table entry holds zero increments, zero limits, zero TATs and tag actions. A policed cell on any connection therefore gets verdict pass with both non-conformance flags low. `out_vld` is low until a cell has been presented.
- R2: While `glb_en` is 0, every cell gets verdict pass, `out_nc`, `out_nc_a` and `out_nc_b` stay 0, `out_clp` equals the cell's CLP, and neither bucket of the connection changes state.
- R3: While `glb_en` is 1, a cell whose bit `vp_en[arr_vp]` is 0 is handled exactly as in R2. A cell is policed only when both enables are 1.
- R4: Bucket A tests every policed cell. It conforms when `arr_time + limit_a >= tat_a`. On conformance, and when the cell is not dropped, `tat_a` becomes `max(tat_a, arr_time) + inc_a`.
- R5: Bucket B tests a policed cell only when the cell's CLP is 0 and bucket A conformed. It uses the same test and update with its own increment, limit and TAT. A cell with CLP=1 never raises `out_nc_b`.
- R6: Verdict codes on `out_verdict`: 0 = pass, 1 = tag, 2 = drop; code 3 never appears. A failing bucket gives drop when its action bit is 1 and tag when it is 0. A tagged cell leaves with `out_clp` = 1, and any other cell leaves with its own CLP.
- R7: A cell that fails bucket A, whether tagged or dropped, is not tested by bucket B, so `out_nc_b` is 0 for it. When the two buckets call for different actions, drop takes priority over tag.
- R8: A failing bucket keeps its TAT. A dropped cell changes neither TAT. A cell tagged by bucket B still advances bucket A.
- R9: The result of a cell strobed on `arr_vld` in cycle c appears with `out_vld` high in cycle c+2, for exactly one cycle for each strobe.
- R10: A host write (`cfg_we`) replaces both increments, both limits and both action bits of entry `cfg_idx` and clears its two TATs to 0. It takes effect for cells strobed in the same cycle as the write or later.
- R11: `out_nc` is 1 exactly when the verdict is not pass. `out_nc_a` and `out_nc_b` report the failing bucket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global policing enable |
| vp_en | input | NVP | Per virtual-path policing enable, one bit per path |
| cfg_we | input | 1 | Host write strobe for one table entry |
| cfg_idx | input | CONN_W | Entry written by the host |
| cfg_inc_a | input | TIME_W | Bucket A increment |
| cfg_lim_a | input | TIME_W | Bucket A limit |
| cfg_inc_b | input | TIME_W | Bucket B increment |
| cfg_lim_b | input | TIME_W | Bucket B limit |
| cfg_drop_a | input | 1 | Bucket A action: 1 drop, 0 tag |
| cfg_drop_b | input | 1 | Bucket B action: 1 drop, 0 tag |
| arr_vld | input | 1 | Cell arrival strobe |
| arr_conn | input | CONN_W | Connection index of the cell |
| arr_vp | input | VP_W | Virtual-path index of the cell |
| arr_clp | input | 1 | CLP bit of the cell |
| arr_time | input | TIME_W | Arrival time of the cell |
| out_vld | output | 1 | Verdict valid |
| out_verdict | output | 2 | 0 pass, 1 tag, 2 drop |
| out_clp | output | 1 | CLP bit after policing |
| out_nc | output | 1 | Cell non-conforming |
| out_nc_a | output | 1 | Bucket A found the cell non-conforming |
| out_nc_b | output | 1 | Bucket B found the cell non-conforming |

## Verification
Random cell streams mix short and long gaps between arrivals, CLP 0 and 1, and random per-connection increments, limits and actions. This tells apart the conform, tag and drop paths of each bucket and exposes any wrong TAT update when cells that follow depend on it. Directed sequences with tight spacing on a connection with a limit of zero separate the "bucket A tags, bucket B skipped" case from the "bucket B tags" and "drop wins" cases. Runs with the global enable and with the per-path enable cleared, each followed by a policed cell, show both that the gate forces pass and that the TAT stayed frozen while the gate was closed. Host writes in the middle of traffic show that the TATs are cleared and the new parameters are used.

// File: rtl/pol_pkg.sv
package pol_pkg;
   typedef enum logic [1:0] {
      VERD_PASS = 2'd0,
      VERD_TAG  = 2'd1,
      VERD_DROP = 2'd2
   } verdict_e;
   localparam int NBKT = 2;
endpackage

// File: rtl/pol_gcra.sv
module pol_gcra #(
   parameter int TIME_W = 20
) (
   input  logic [TIME_W-1:0] t_now,
   input  logic [TIME_W-1:0] tat,
   input  logic [TIME_W-1:0] inc,
   input  logic [TIME_W-1:0] lim,
   output logic              ok,
   output logic [TIME_W-1:0] tat_next
);
   logic [TIME_W:0]   reach;
   logic [TIME_W-1:0] base;

   always_comb begin
      reach    = {1'b0, t_now} + {1'b0, lim};
      ok       = (reach >= {1'b0, tat});
      base     = (t_now > tat) ? t_now : tat;
      tat_next = base + inc;
   end
endmodule

// File: rtl/pol_ctab.sv
module pol_ctab #(
   parameter int NCONN  = 8,
   parameter int TIME_W = 20,
   localparam int CONN_W = (NCONN > 1) ? $clog2(NCONN) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [CONN_W-1:0]      wr_idx,
   input  logic [1:0][TIME_W-1:0] wr_inc,
   input  logic [1:0][TIME_W-1:0] wr_lim,
   input  logic [1:0]             wr_drop,
   input  logic [1:0]             upd_en,
   input  logic [CONN_W-1:0]      upd_idx,
   input  logic [1:0][TIME_W-1:0] upd_tat,
   input  logic [CONN_W-1:0]      rd_idx,
   output logic [1:0][TIME_W-1:0] rd_inc,
   output logic [1:0][TIME_W-1:0] rd_lim,
   output logic [1:0]             rd_drop,
   output logic [1:0][TIME_W-1:0] rd_tat
);
   logic [1:0][TIME_W-1:0] inc_q  [NCONN];
   logic [1:0][TIME_W-1:0] lim_q  [NCONN];
   logic [1:0][TIME_W-1:0] tat_q  [NCONN];
   logic [1:0]             drop_q [NCONN];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < NCONN; e++) begin
            inc_q[e]  <= '0;
            lim_q[e]  <= '0;
            tat_q[e]  <= '0;
            drop_q[e] <= '0;
         end
      end else begin
         for (int e = 0; e < NCONN; e++) begin
            if (wr_en && wr_idx == CONN_W'(e)) begin
               inc_q[e]  <= wr_inc;
               lim_q[e]  <= wr_lim;
               drop_q[e] <= wr_drop;
               tat_q[e]  <= '0;
            end else if (upd_idx == CONN_W'(e)) begin
               for (int b = 0; b < 2; b++)
                  if (upd_en[b]) tat_q[e][b] <= upd_tat[b];
            end
         end
      end
   end

   assign rd_inc  = inc_q[rd_idx];
   assign rd_lim  = lim_q[rd_idx];
   assign rd_tat  = tat_q[rd_idx];
   assign rd_drop = drop_q[rd_idx];

   // R10: a host write leaves the written entry with cleared TATs
   assert_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (tat_q[$past(wr_idx)] == '0));
endmodule

// File: rtl/cell_policer.sv
module cell_policer
   import pol_pkg::*;
#(
   parameter int NCONN  = 8,
   parameter int NVP    = 4,
   parameter int TIME_W = 20,
   localparam int CONN_W = (NCONN > 1) ? $clog2(NCONN) : 1,
   localparam int VP_W   = (NVP > 1) ? $clog2(NVP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glb_en,
   input  logic [NVP-1:0]    vp_en,
   input  logic              cfg_we,
   input  logic [CONN_W-1:0] cfg_idx,
   input  logic [TIME_W-1:0] cfg_inc_a,
   input  logic [TIME_W-1:0] cfg_lim_a,
   input  logic [TIME_W-1:0] cfg_inc_b,
   input  logic [TIME_W-1:0] cfg_lim_b,
   input  logic              cfg_drop_a,
   input  logic              cfg_drop_b,
   input  logic              arr_vld,
   input  logic [CONN_W-1:0] arr_conn,
   input  logic [VP_W-1:0]   arr_vp,
   input  logic              arr_clp,
   input  logic [TIME_W-1:0] arr_time,
   output logic              out_vld,
   output logic [1:0]        out_verdict,
   output logic              out_clp,
   output logic              out_nc,
   output logic              out_nc_a,
   output logic              out_nc_b
);
   if (TIME_W < 4 || TIME_W > 62) begin : g_bad_time
      $error("cell_policer: TIME_W out of range");
   end
   if (NCONN < 1 || NVP < 1) begin : g_bad_count
      $error("cell_policer: NCONN and NVP must be positive");
   end

   // stage 1: captured arrival
   logic              s1_vld, s1_pol, s1_clp;
   logic [CONN_W-1:0] s1_conn;
   logic [TIME_W-1:0] s1_time;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_pol  <= 1'b0;
         s1_clp  <= 1'b0;
         s1_conn <= '0;
         s1_time <= '0;
      end else begin
         s1_vld  <= arr_vld;
         s1_pol  <= glb_en & vp_en[arr_vp];
         s1_clp  <= arr_clp;
         s1_conn <= arr_conn;
         s1_time <= arr_time;
      end
   end

   // connection table
   logic [1:0][TIME_W-1:0] t_inc, t_lim, t_tat, new_tat;
   logic [1:0]             t_drop, upd_en;

   pol_ctab #(.NCONN(NCONN), .TIME_W(TIME_W)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_idx  (cfg_idx),
      .wr_inc  ({cfg_inc_b, cfg_inc_a}),
      .wr_lim  ({cfg_lim_b, cfg_lim_a}),
      .wr_drop ({cfg_drop_b, cfg_drop_a}),
      .upd_en  (upd_en),
      .upd_idx (s1_conn),
      .upd_tat (new_tat),
      .rd_idx  (s1_conn),
      .rd_inc  (t_inc),
      .rd_lim  (t_lim),
      .rd_drop (t_drop),
      .rd_tat  (t_tat)
   );

   // stage 2: bucket evaluation
   logic [1:0] bkt_ok, bkt_ev, bkt_fail;

   for (genvar b = 0; b < NBKT; b++) begin : g_bkt
      pol_gcra #(.TIME_W(TIME_W)) u_gcra (
         .t_now    (s1_time),
         .tat      (t_tat[b]),
         .inc      (t_inc[b]),
         .lim      (t_lim[b]),
         .ok       (bkt_ok[b]),
         .tat_next (new_tat[b])
      );
   end

   logic     drop_any, tag_any;
   verdict_e verd;

   always_comb begin
      bkt_ev[0]   = s1_vld & s1_pol;
      bkt_ev[1]   = s1_vld & s1_pol & ~s1_clp & bkt_ok[0];
      bkt_fail    = bkt_ev & ~bkt_ok;
      drop_any    = |(bkt_fail & t_drop);
      tag_any     = |bkt_fail;
      if (drop_any)     verd = VERD_DROP;
      else if (tag_any) verd = VERD_TAG;
      else              verd = VERD_PASS;
      upd_en      = (drop_any) ? 2'b00 : (bkt_ev & bkt_ok);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld     <= 1'b0;
         out_verdict <= VERD_PASS;
         out_clp     <= 1'b0;
         out_nc      <= 1'b0;
         out_nc_a    <= 1'b0;
         out_nc_b    <= 1'b0;
      end else begin
         out_vld     <= s1_vld;
         out_verdict <= s1_vld ? verd : VERD_PASS;
         out_clp     <= s1_vld & (s1_clp | (verd == VERD_TAG));
         out_nc      <= s1_vld & (verd != VERD_PASS);
         out_nc_a    <= bkt_fail[0];
         out_nc_b    <= bkt_fail[1];
      end
   end

   // R9: fixed two-cycle latency
   assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      arr_vld |-> ##2 out_vld);
   // R11: a passing cell carries no non-conformance flag
   assert_pass_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_verdict == VERD_PASS) |-> (!out_nc && !out_nc_a && !out_nc_b));
   // R6: a tagged cell leaves with CLP set
   assert_tag_clp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_verdict == VERD_TAG) |-> out_clp);
   // R6: unused verdict code never appears
   assert_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_verdict != 2'b11);
   // R7: bucket B is skipped once bucket A failed
   assert_skip_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_nc_a |-> !out_nc_b);
   // R5: a CLP=1 cell never fails bucket B
   assert_clp1_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && s1_clp) |=> !out_nc_b);
   // R2: an unpoliced cell changes no TAT
   assert_gate_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && !s1_pol) |-> (upd_en == 2'b00));
endmodule

// File: tb/sim_cell_policer.sv
module sim_cell_policer;
   localparam int CLK_P  = 10;
   localparam int NCONN  = 8;
   localparam int NVP    = 4;
   localparam int TIME_W = 20;
   localparam int CW     = 3;
   localparam int VW     = 2;

   logic clk = 1'b0, rst_n = 1'b0, glb_en = 1'b0;
   logic [NVP-1:0] vp_en = '0;
   logic cfg_we = 1'b0, cfg_drop_a = 1'b0, cfg_drop_b = 1'b0;
   logic [CW-1:0] cfg_idx = '0;
   logic [TIME_W-1:0] cfg_inc_a = '0, cfg_lim_a = '0, cfg_inc_b = '0, cfg_lim_b = '0;
   logic arr_vld = 1'b0, arr_clp = 1'b0;
   logic [CW-1:0] arr_conn = '0;
   logic [VW-1:0] arr_vp = '0;
   logic [TIME_W-1:0] arr_time = '0;
   logic out_vld, out_clp, out_nc, out_nc_a, out_nc_b;
   logic [1:0] out_verdict;

   cell_policer #(.NCONN(NCONN), .NVP(NVP), .TIME_W(TIME_W)) u0 (.*);

   always #(CLK_P/2) clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0;
   int m_inc [NCONN][2], m_lim [NCONN][2], m_tat [NCONN][2], m_drop [NCONN][2];
   int now_t = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic host_wr(input int c, input int ia, input int la, input int ib,
                          input int lb, input int da, input int db);
      @(negedge clk);
      cfg_we = 1; cfg_idx = CW'(c);
      cfg_inc_a = TIME_W'(ia); cfg_lim_a = TIME_W'(la);
      cfg_inc_b = TIME_W'(ib); cfg_lim_b = TIME_W'(lb);
      cfg_drop_a = da[0]; cfg_drop_b = db[0];
      @(negedge clk);
      cfg_we = 0;
      m_inc[c][0] = ia; m_lim[c][0] = la; m_inc[c][1] = ib; m_lim[c][1] = lb;
      m_drop[c][0] = da; m_drop[c][1] = db; m_tat[c][0] = 0; m_tat[c][1] = 0;
   endtask

   // expected behaviour from the requirements
   task automatic model(input int c, input int vp, input int clp, input int t,
                        output int v, output int eclp, output int na, output int nb);
      bit pol, oka, okb, evb;
      int nta, ntb;
      v = 0; eclp = clp; na = 0; nb = 0;
      pol = glb_en && vp_en[vp];
      if (!pol) return;
      oka = (t + m_lim[c][0] >= m_tat[c][0]);
      nta = ((t > m_tat[c][0]) ? t : m_tat[c][0]) + m_inc[c][0];
      evb = oka && (clp == 0);
      okb = (t + m_lim[c][1] >= m_tat[c][1]);
      ntb = ((t > m_tat[c][1]) ? t : m_tat[c][1]) + m_inc[c][1];
      if (!oka) begin na = 1; v = m_drop[c][0] ? 2 : 1; end
      else if (evb && !okb) begin nb = 1; v = m_drop[c][1] ? 2 : 1; end
      if (v == 1) eclp = 1;
      if (v != 2) begin
         if (oka) m_tat[c][0] = nta;
         if (evb && okb) m_tat[c][1] = ntb;
      end
   endtask

   task automatic send(input int c, input int vp, input int clp, input int gap, input string req);
      int ev, ec, ea, eb;
      now_t += gap;
      @(negedge clk);
      arr_vld = 1; arr_conn = CW'(c); arr_vp = VW'(vp); arr_clp = clp[0];
      arr_time = TIME_W'(now_t);
      model(c, vp, clp, now_t, ev, ec, ea, eb);
      @(negedge clk);
      arr_vld = 0;
      chk(out_vld == 0, "R9 early", int'(out_vld), 0);
      @(negedge clk);
      chk(out_vld == 1, "R9 valid", int'(out_vld), 1);
      chk(int'(out_verdict) == ev, {req, " verdict"}, int'(out_verdict), ev);
      chk(int'(out_clp) == ec, {req, " clp R6"}, int'(out_clp), ec);
      chk(int'(out_nc_a) == ea && int'(out_nc_b) == eb,
          {req, " bucket flags R11"}, int'({out_nc_a, out_nc_b}), ea*2 + eb);
      chk(int'(out_nc) == int'(ev != 0), {req, " nc R11"}, int'(out_nc), int'(ev != 0));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h5eed_0042;
      void'($urandom(seed));
      for (int c = 0; c < NCONN; c++)
         for (int b = 0; b < 2; b++) begin
            m_inc[c][b] = 0; m_lim[c][b] = 0; m_tat[c][b] = 0; m_drop[c][b] = 0;
         end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(out_vld == 0, "R1 reset out_vld", int'(out_vld), 0);
      glb_en = 1; vp_en = '1;
      // R1: default entries pass everything, even back-to-back
      for (int i = 0; i < 6; i++) send(i, i % NVP, i % 2, 0, "R1");

      // R4/R7: limit zero, tight spacing: bucket A tags, bucket B skipped
      host_wr(1, 50, 0, 10, 0, 0, 1);
      send(1, 0, 0, 1, "R4");
      send(1, 0, 0, 1, "R7 tag by A");
      // R8: tagged cell left TAT alone; after the gap the cell conforms
      send(1, 0, 0, 60, "R8");
      // R5: bucket B tags a CLP0 cell while A conforms (drop_b so drop)
      host_wr(2, 1, 0, 40, 0, 1, 1);
      send(2, 1, 0, 2, "R5");
      send(2, 1, 0, 2, "R5 b fails drop");
      send(2, 1, 1, 2, "R5 clp1 skips B");
      // R7: A drop, B skipped
      host_wr(3, 30, 0, 1, 0, 1, 0);
      send(3, 2, 0, 1, "R7");
      send(3, 2, 0, 1, "R7 drop by A");
      send(3, 2, 0, 1, "R8 dropped no update");

      // R2: global enable off, tight traffic passes untouched
      glb_en = 0;
      for (int i = 0; i < 4; i++) send(1, 0, 0, 0, "R2");
      glb_en = 1;
      send(1, 0, 0, 0, "R2 state frozen");
      // R3: path enable off
      vp_en = 4'b1101;
      for (int i = 0; i < 4; i++) send(3, 1, 0, 0, "R3");
      send(3, 0, 0, 0, "R3 other path policed");
      vp_en = '1;
      send(3, 1, 0, 0, "R3 path back on");

      // R10: write mid-traffic clears TATs
      host_wr(1, 5, 2, 9, 3, 0, 0);
      send(1, 0, 0, 0, "R10");

      // random traffic
      for (int c = 0; c < NCONN; c++)
         host_wr(c, 2 + $urandom % 19, $urandom % 31, 2 + $urandom % 19,
                 $urandom % 31, $urandom % 2, $urandom % 2);
      for (int i = 0; i < 2500; i++) begin
         if ($urandom % 200 == 0)
            host_wr($urandom % NCONN, 2 + $urandom % 19, $urandom % 31,
                    2 + $urandom % 19, $urandom % 31, $urandom % 2, $urandom % 2);
         if ($urandom % 50 == 0) vp_en = NVP'($urandom);
         else if ($urandom % 50 == 0) vp_en = '1;
         glb_en = ($urandom % 40 != 0);
         send($urandom % NCONN, $urandom % NVP, ($urandom % 4 == 0) ? 1 : 0,
              $urandom % 16, "R4/R5/R6/R8 random");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule